// File: doc/BRIEF.md
# Multi-Source Synchronous Reset Generator

This block produces the internal reset for a small microcontroller core. It merges three sources into one synchronous reset: an external reset pin, a level from a power-on/power-fail detector, and a reset request from the watchdog. The external pin passes through a synchronizer. It is then sampled once per machine cycle, at the last phase of that cycle. It counts as a reset only after it has been seen high on consecutive samples.

When every source has gone away, the reset is held for a further number of machine cycles, and it is released only on a machine-cycle boundary. A program-counter clear output covers the whole reset period and one clock beyond it, so the fetch logic starts from address zero.

Two cause flags record power-on and watchdog resets. An external reset sets neither flag, so software reads both flags clear as an external reset. Software clears a flag by writing 0 to its bit.

Top module: `rstgen_top`

## Requirements
- R1: While rst_ni is low, core_rst_o and pc_clr_o are 1, por_flag_o is 1 and wdt_flag_o is 0.
- R2: A machine cycle is CLKS_PER_MC (4) clocks. After a two-flop synchronizer, ext_rst_i is sampled once per machine cycle, on its last phase. It takes effect only after QUAL_MC (2) consecutive high samples. A pin pulse of 4 clocks never asserts core_rst_o. A pulse of 8 clocks always asserts it.
- R3: core_rst_o stays 1 for as long as a qualified external pin stays high.
- R4: por_i or wdt_rst_i high for one clock makes core_rst_o 1 from the next clock.
- R5: After the last source goes away, core_rst_o stays high across STRETCH_MC (2) further machine-cycle boundaries and falls only at a boundary. After rst_ni rises, core_rst_o is 1 after the 7th clock edge and 0 after the 8th. After a one-clock watchdog pulse it falls 6 to 9 edges after the pulse. After a held pin is released it falls 11 to 14 edges after the release.
- R6: pc_clr_o is 1 whenever core_rst_o is 1, and also for exactly one clock after core_rst_o falls.
- R7: An external-pin reset changes neither flag.
- R8: A flag write with flag_we_i=1 uses bit 0 of flag_wd_i for the power-on flag and bit 1 for the watchdog flag. A bit written 0 clears its flag and a bit written 1 leaves it unchanged. A set from por_i or wdt_rst_i in the same clock wins over the clear.
- R9: por_i sets only por_flag_o, and wdt_rst_i sets only wdt_flag_o. The other flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous power-up clear, active low |
| ext_rst_i | input | 1 | External reset pin, asynchronous, active high |
| por_i | input | 1 | Power-on/power-fail detector level, synchronous |
| wdt_rst_i | input | 1 | Watchdog reset request, synchronous |
| flag_we_i | input | 1 | Software write strobe for the flags |
| flag_wd_i | input | 2 | Write data: bit 0 power-on, bit 1 watchdog, 0 clears |
| core_rst_o | output | 1 | Internal synchronous reset |
| pc_clr_o | output | 1 | Program counter clear |
| por_flag_o | output | 1 | Power-on reset cause flag |
| wdt_flag_o | output | 1 | Watchdog reset cause flag |

## Verification
The external pin is driven with a 4-clock pulse and with an 8-clock pulse. Since either width covers a fixed number of sample phases, these two cases separate one-sample acceptance from two-sample qualification, whatever the phase alignment. A long hold, released at four different phase offsets, shows that reset is held while the pin is high. It also bounds the stretch window after release. One-clock watchdog and power-on pulses check that the reset is immediate and that each flag is kept separate. Combined writes and simultaneous set-with-clear show which bit maps to which flag and which action has priority.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int FLAG_POR = 0;
  localparam int FLAG_WDT = 1;
  localparam int NUM_FLAGS = 2;
  typedef logic [NUM_FLAGS-1:0] cause_t;
endpackage

// File: rtl/rstgen_phase.sv
module rstgen_phase #(
  parameter int CLKS_PER_MC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_o
);
  localparam int PW = (CLKS_PER_MC > 2) ? $clog2(CLKS_PER_MC) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MC - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                  ph_q <= ph_q + 1'b1;
  end

  assign strobe_o = (ph_q == LAST);

  // R2: one sample strobe per machine cycle, phase never out of range
  assert_phase_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= LAST);
  assert_strobe_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/rstgen_qual.sv
module rstgen_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_MC     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic strobe_i,
  output logic hold_o
);
  localparam int CW = $clog2(QUAL_MC + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_MC);

  logic [SYNC_STAGES-1:0] sff_q;
  logic [CW-1:0]          hi_q;
  logic                   pin_s;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sff_q[g] <= 1'b0;
        else         sff_q[g] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sff_q[g] <= 1'b0;
        else         sff_q[g] <= sff_q[g-1];
    end
  end

  assign pin_s = sff_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_q <= '0;
    else if (strobe_i) begin
      if (!pin_s)          hi_q <= '0;
      else if (hi_q != QMAX) hi_q <= hi_q + 1'b1;
    end
  end

  assign hold_o = (hi_q == QMAX);

  // R2: qualification only completes on a sample strobe with the pin high
  assert_qual_on_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(strobe_i) && $past(pin_s));
  assert_drop_on_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $past(strobe_i));
endmodule

// File: rtl/rstgen_flags.sv
module rstgen_flags
  import rstgen_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   por_i,
  input  logic   wdt_i,
  input  logic   we_i,
  input  cause_t wd_i,
  output cause_t flags_o
);
  cause_t flags_q, set_v, clr_v;

  always_comb begin
    set_v           = '0;
    set_v[FLAG_POR] = por_i;
    set_v[FLAG_WDT] = wdt_i;
    clr_v           = we_i ? ~wd_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q           <= '0;
      flags_q[FLAG_POR] <= 1'b1;
    end else begin
      flags_q <= (flags_q & ~clr_v) | set_v;
    end
  end

  assign flags_o = flags_q;

  assert_por_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> flags_o[FLAG_POR]);
  assert_wdt_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_i |=> flags_o[FLAG_WDT]);
  assert_por_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && !we_i) |=> $stable(flags_o[FLAG_POR]));
  assert_wr_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wd_i[FLAG_WDT] && !wdt_i) |=> !flags_o[FLAG_WDT]);
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
  import rstgen_pkg::*;
#(
  parameter int CLKS_PER_MC = 4,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_MC     = 2,
  parameter int STRETCH_MC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_i,
  input  logic       por_i,
  input  logic       wdt_rst_i,
  input  logic       flag_we_i,
  input  logic [1:0] flag_wd_i,
  output logic       core_rst_o,
  output logic       pc_clr_o,
  output logic       por_flag_o,
  output logic       wdt_flag_o
);
  localparam int SW = $clog2(STRETCH_MC + 1);
  localparam logic [SW-1:0] SMAX = SW'(STRETCH_MC);

  logic          mc_strobe, ext_hold, src_req, rst_dly_q;
  logic [SW-1:0] str_q;
  cause_t        flags;

  rstgen_phase #(.CLKS_PER_MC(CLKS_PER_MC)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_o(mc_strobe));

  rstgen_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_MC(QUAL_MC)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ext_rst_i),
    .strobe_i(mc_strobe), .hold_o(ext_hold));

  rstgen_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .por_i(por_i), .wdt_i(wdt_rst_i),
    .we_i(flag_we_i), .wd_i(flag_wd_i), .flags_o(flags));

  assign src_req = ext_hold | por_i | wdt_rst_i;

  // stretch: reload while any source is active, count down on boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       str_q <= SMAX;
    else if (src_req)                  str_q <= SMAX;
    else if (mc_strobe && str_q != '0) str_q <= str_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_dly_q <= 1'b1;
    else         rst_dly_q <= core_rst_o;
  end

  assign core_rst_o = (str_q != '0);
  assign pc_clr_o   = core_rst_o | rst_dly_q;
  assign por_flag_o = flags[FLAG_POR];
  assign wdt_flag_o = flags[FLAG_WDT];

  assert_src_rst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i || wdt_rst_i) |=> core_rst_o);
  assert_pin_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_hold |=> core_rst_o);
  assert_release_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> $past(mc_strobe) && !$past(src_req));
  assert_pc_trail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> pc_clr_o);
  assert_ext_noflag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && !wdt_rst_i && !flag_we_i) |=> $stable(flags));
endmodule

// File: tb/rstgen_top_bench.sv
module rstgen_top_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_rst = 1'b0, por = 1'b0, wdt = 1'b0, we = 1'b0;
  logic [1:0] wd = 2'b11;
  logic core_rst, pc_clr, por_flag, wdt_flag;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rstgen_top u_rstgen_top (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_i(ext_rst), .por_i(por),
    .wdt_rst_i(wdt), .flag_we_i(we), .flag_wd_i(wd),
    .core_rst_o(core_rst), .pc_clr_o(pc_clr),
    .por_flag_o(por_flag), .wdt_flag_o(wdt_flag));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // count negedges until core_rst low, starting after the next posedge
  task automatic edges_to_release(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (core_rst && n < 60);
  endtask

  task automatic t_power_on();
    repeat (3) @(negedge clk);
    check("R1 core_rst", core_rst, 1);
    check("R1 pc_clr", pc_clr, 1);
    check("R1 por_flag", por_flag, 1);
    check("R1 wdt_flag", wdt_flag, 0);
    rst_ni = 1'b1;
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      if (i == 7) check("R5 rst held at edge 7", core_rst, 1);
      if (i == 8) begin
        check("R5 rst released at edge 8", core_rst, 0);
        check("R6 pc_clr trails one clock", pc_clr, 1);
      end
      if (i == 9) check("R6 pc_clr low after trail", pc_clr, 0);
    end
  endtask

  task automatic t_clear_all();
    we = 1'b1; wd = 2'b00;
    @(negedge clk);
    we = 1'b0; wd = 2'b11;
    check("R8 por cleared", por_flag, 0);
    check("R8 wdt cleared", wdt_flag, 0);
  endtask

  task automatic t_short_pin();
    int seen = 0;
    ext_rst = 1'b1;
    repeat (4) @(negedge clk);
    ext_rst = 1'b0;
    repeat (24) begin
      @(negedge clk);
      if (core_rst) seen++;
    end
    check("R2 4-clock pulse ignored", seen, 0);
  endtask

  task automatic t_min_pin();
    int seen = 0;
    int n;
    ext_rst = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (core_rst) seen = 1;
    end
    ext_rst = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (core_rst) seen = 1;
    end
    check("R2 8-clock pulse accepted", seen, 1);
    edges_to_release(n);
    check("R7 ext leaves por flag", por_flag, 0);
    check("R7 ext leaves wdt flag", wdt_flag, 0);
  endtask

  task automatic t_held_pin(input int off);
    int lows = 0;
    int n;
    repeat (off) @(negedge clk);
    ext_rst = 1'b1;
    repeat (12) @(negedge clk);
    check("R3 rst asserted by held pin", core_rst, 1);
    repeat (40) begin
      @(negedge clk);
      if (!core_rst) lows++;
    end
    check("R3 rst held while pin high", lows, 0);
    ext_rst = 1'b0;
    edges_to_release(n);
    check_rng("R5 pin release stretch", n, 11, 14);
  endtask

  task automatic t_wdt();
    int n;
    wdt = 1'b1;
    @(negedge clk);
    wdt = 1'b0;
    check("R4 wdt asserts rst", core_rst, 1);
    check("R9 wdt flag set", wdt_flag, 1);
    check("R9 por flag untouched by wdt", por_flag, 0);
    edges_to_release(n);
    check_rng("R5 wdt stretch", n + 1, 6, 9);
  endtask

  task automatic t_por();
    int n;
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    check("R4 por asserts rst", core_rst, 1);
    check("R9 por flag set", por_flag, 1);
    check("R9 wdt flag kept", wdt_flag, 1);
    edges_to_release(n);
  endtask

  task automatic t_partial_clear();
    we = 1'b1; wd = 2'b01;
    @(negedge clk);
    we = 1'b0; wd = 2'b11;
    check("R8 bit0=1 keeps por", por_flag, 1);
    check("R8 bit1=0 clears wdt", wdt_flag, 0);
    we = 1'b1; wd = 2'b10;
    @(negedge clk);
    we = 1'b0; wd = 2'b11;
    check("R8 bit0=0 clears por", por_flag, 0);
  endtask

  task automatic t_set_wins();
    int n;
    wdt = 1'b1; we = 1'b1; wd = 2'b00;
    @(negedge clk);
    wdt = 1'b0; we = 1'b0; wd = 2'b11;
    check("R8 set beats clear", wdt_flag, 1);
    check("R8 por stays clear", por_flag, 0);
    edges_to_release(n);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_power_on();
    t_clear_all();
    t_short_pin();
    t_min_pin();
    for (int k = 0; k < 4; k++) t_held_pin(k);
    t_wdt();
    t_por();
    t_partial_clear();
    t_set_wins();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule